// File: doc/BRIEF.md
# Two-Phase Time-Division Slot Scheduler

This block shares one resource among several virtual clients by stepping through a repeating table of slots. Each slot opens with a supervisor phase of fixed length. A client phase of fixed length follows it. During the client phase, the client that owns the slot holds a one-hot grant. A slot with no owner leaves the resource idle for the whole client phase. A client that owns k of the n slots therefore receives k·C service cycles in every table of n·(P+C) cycles. Here P is the supervisor length and C is the client length. The supervisor overhead is paid inside every slot.

The block comes out of reset in configuration mode. In that mode the phase lengths, the table length and the owner of each slot can be loaded. When the mode input falls, the schedule starts at slot 0 and runs until the next reset. From then on, all configuration writes are ignored. The block also gives a one-cycle table-start pulse, which lets several instances be compared for alignment. Each client has a counter of the cycles it has been granted, so that the service rate can be checked.

Top module: `tdm_slot_sched`

## Requirements
- R1: While reset is high, and until the schedule starts, `running`, `sup_active`, `in_client`, `table_start` and `grant` are 0. Every service counter is 0.
- R2: The schedule starts when `cfg_mode` is low. The first running cycle is the supervisor phase of slot 0. Every slot then runs its supervisor phase for exactly P cycles, followed by its client phase for exactly C cycles. The slot index does not change between those two phases.
- R3: During a client phase, `grant` equals one-hot of the owner client of the current slot. Bit i of `grant` is client i. `grant` is never set during a supervisor phase and never has more than one bit set.
- R4: A slot whose owner entry is marked not valid produces no grant during its client phase. That client phase still lasts the full C cycles.
- R5: After the client phase of the last slot (table length minus 1), the slot index wraps to 0. After any other slot, it increments by 1. `table_start` is high exactly on the first cycle of the supervisor phase of slot 0.
- R6: A phase length of 0 acts as 1 cycle. A table length of 0 acts as 1 slot. A table length above the table capacity acts as the full capacity.
- R7: Once the schedule has started, writes to the owner table and to the length registers have no effect. Raising `cfg_mode` again has no effect either. Only reset returns the block to configuration mode.
- R8: Service counter i (bits i·CNT_W upward in `svc_count`) goes up by one for each cycle in which grant bit i is high. It is visible one cycle later. A client owning k of n slots therefore gains k·C per table of n·(P+C) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | High: configuration mode; low: start the schedule |
| cfg_time_wr | input | 1 | Loads the two phase lengths and the table length |
| cfg_sup_len | input | DUR_W | Supervisor phase length in cycles |
| cfg_cli_len | input | DUR_W | Client phase length in cycles |
| cfg_slots | input | clog2(SLOTS+1) | Number of slots in the table |
| cfg_own_wr | input | 1 | Writes one owner table entry |
| cfg_own_slot | input | clog2(SLOTS) | Slot index of the owner entry |
| cfg_own_client | input | clog2(CLIENTS) | Owner client of that slot |
| cfg_own_valid | input | 1 | 1: slot owned, 0: slot unowned |
| running | output | 1 | Schedule active |
| sup_active | output | 1 | Supervisor phase in progress |
| in_client | output | 1 | Client phase in progress |
| slot_idx | output | clog2(SLOTS) | Current slot |
| table_start | output | 1 | First cycle of slot 0 |
| grant | output | CLIENTS | One-hot client grant |
| svc_count | output | CLIENTS*CNT_W | Per-client granted-cycle counters |

## Verification
A cycle-by-cycle model of the expected outputs runs against four configurations.

- **Mixed table.** A four-slot table has one client owning two non-adjacent slots, one unowned slot and a second client. It tells ownership lookup apart from phase timing and shows that an idle slot keeps its length.
- **Zero settings.** A table with zero lengths and zero slots separates the one-cycle fallback from a stall.
- **Writes while running.** A short run receives owner and length writes, and a raised mode input, while it is active. This exposes any leak of configuration after start.
- **Ten-slot rate.** A ten-slot table with half its slots owned by one client is compared against the 8-in-17 service ratio over one whole table.

// File: rtl/tdm_sched_pkg.sv
package tdm_sched_pkg;

  typedef enum logic {
    PH_SUP = 1'b0,
    PH_CLI = 1'b1
  } phase_e;

  // Counter reload for a programmed length: a zero length still lasts one cycle.
  function automatic logic [31:0] reload_of(input logic [31:0] len);
    return (len == 32'd0) ? 32'd0 : len - 32'd1;
  endfunction

endpackage

// File: rtl/tdm_owner_table.sv
module tdm_owner_table #(
  parameter int SLOTS   = 16,
  parameter int SLOT_W  = 4,
  parameter int CID_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [CID_W-1:0]  wr_id,
  input  logic              wr_valid,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [CID_W-1:0]  rd_id,
  output logic              rd_valid
);

  logic [CID_W-1:0] id_mem [SLOTS];
  logic [SLOTS-1:0] vld_q;

  // Owner ids carry no reset so the array can map onto distributed RAM.
  always_ff @(posedge clk) begin
    if (wr_en) id_mem[wr_slot] <= wr_id;
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else if (wr_en) vld_q[wr_slot] <= wr_valid;
  end

  assign rd_id    = id_mem[rd_slot];
  assign rd_valid = vld_q[rd_slot];

endmodule

// File: rtl/tdm_phase_seq.sv
module tdm_phase_seq
  import tdm_sched_pkg::*;
#(
  parameter int SLOT_W = 4,
  parameter int DUR_W  = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [DUR_W-1:0]  sup_rl,
  input  logic [DUR_W-1:0]  cli_rl,
  input  logic [SLOT_W-1:0] last_slot,
  output logic              run_q,
  output phase_e            phase_q,
  output logic [SLOT_W-1:0] slot_q,
  output logic              start_q,
  output logic              nxt_run,
  output phase_e            nxt_phase,
  output logic [SLOT_W-1:0] nxt_slot
);

  logic [DUR_W-1:0] rem_q, nxt_rem;
  logic             nxt_start;

  always_comb begin
    nxt_run   = run_q;
    nxt_phase = phase_q;
    nxt_slot  = slot_q;
    nxt_rem   = rem_q;
    nxt_start = 1'b0;
    if (!run_q) begin
      if (go) begin
        nxt_run   = 1'b1;
        nxt_phase = PH_SUP;
        nxt_slot  = '0;
        nxt_rem   = sup_rl;
        nxt_start = 1'b1;
      end
    end else if (rem_q != '0) begin
      nxt_rem = rem_q - 1'b1;
    end else if (phase_q == PH_SUP) begin
      nxt_phase = PH_CLI;
      nxt_rem   = cli_rl;
    end else begin
      nxt_phase = PH_SUP;
      nxt_rem   = sup_rl;
      if (slot_q == last_slot) begin
        nxt_slot  = '0;
        nxt_start = 1'b1;
      end else begin
        nxt_slot = slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      phase_q <= PH_SUP;
      slot_q  <= '0;
      rem_q   <= '0;
      start_q <= 1'b0;
    end else begin
      run_q   <= nxt_run;
      phase_q <= nxt_phase;
      slot_q  <= nxt_slot;
      rem_q   <= nxt_rem;
      start_q <= nxt_start;
    end
  end

endmodule

// File: rtl/tdm_svc_counters.sv
module tdm_svc_counters #(
  parameter int CLIENTS = 4,
  parameter int CNT_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CLIENTS-1:0]       grant,
  output logic [CLIENTS*CNT_W-1:0] counts
);

  for (genvar i = 0; i < CLIENTS; i++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else if (grant[i] && (cnt_q != {CNT_W{1'b1}})) cnt_q <= cnt_q + 1'b1;
    end
    assign counts[i*CNT_W +: CNT_W] = cnt_q;
  end

endmodule

// File: rtl/tdm_slot_sched.sv
module tdm_slot_sched
  import tdm_sched_pkg::*;
#(
  parameter int SLOTS   = 16,
  parameter int CLIENTS = 4,
  parameter int DUR_W   = 18,
  parameter int CNT_W   = 32
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      cfg_mode,
  input  logic                                      cfg_time_wr,
  input  logic [DUR_W-1:0]                          cfg_sup_len,
  input  logic [DUR_W-1:0]                          cfg_cli_len,
  input  logic [$clog2(SLOTS+1)-1:0]                cfg_slots,
  input  logic                                      cfg_own_wr,
  input  logic [$clog2(SLOTS)-1:0]                  cfg_own_slot,
  input  logic [((CLIENTS > 1) ? $clog2(CLIENTS) : 1)-1:0] cfg_own_client,
  input  logic                                      cfg_own_valid,
  output logic                                      running,
  output logic                                      sup_active,
  output logic                                      in_client,
  output logic [$clog2(SLOTS)-1:0]                  slot_idx,
  output logic                                      table_start,
  output logic [CLIENTS-1:0]                        grant,
  output logic [CLIENTS*CNT_W-1:0]                  svc_count
);

  localparam int SLOT_W = $clog2(SLOTS);
  localparam int NSL_W  = $clog2(SLOTS + 1);
  localparam int CID_W  = (CLIENTS > 1) ? $clog2(CLIENTS) : 1;

  logic [DUR_W-1:0]  sup_len_q, cli_len_q, sup_rl, cli_rl;
  logic [NSL_W-1:0]  nsl_q, last_wide;
  logic [SLOT_W-1:0] last_slot;
  logic              run_q, start_q, nxt_run;
  phase_e            phase_q, nxt_phase;
  logic [SLOT_W-1:0] slot_q, nxt_slot;
  logic [CID_W-1:0]  own_id;
  logic              own_vld;
  logic [CLIENTS-1:0] grant_q;

  // Length registers accept writes only before the schedule starts.
  always_ff @(posedge clk) begin
    if (rst) begin
      sup_len_q <= '0;
      cli_len_q <= '0;
      nsl_q     <= '0;
    end else if (cfg_time_wr && !run_q) begin
      sup_len_q <= cfg_sup_len;
      cli_len_q <= cfg_cli_len;
      nsl_q     <= cfg_slots;
    end
  end

  assign sup_rl = DUR_W'(reload_of(32'(sup_len_q)));
  assign cli_rl = DUR_W'(reload_of(32'(cli_len_q)));

  always_comb begin
    if (nsl_q == '0)                  last_wide = '0;
    else if (nsl_q > NSL_W'(SLOTS))   last_wide = NSL_W'(SLOTS - 1);
    else                              last_wide = nsl_q - 1'b1;
  end
  assign last_slot = last_wide[SLOT_W-1:0];

  tdm_owner_table #(
    .SLOTS (SLOTS),
    .SLOT_W(SLOT_W),
    .CID_W (CID_W)
  ) u_owner (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_own_wr && !run_q),
    .wr_slot (cfg_own_slot),
    .wr_id   (cfg_own_client),
    .wr_valid(cfg_own_valid),
    .rd_slot (nxt_slot),
    .rd_id   (own_id),
    .rd_valid(own_vld)
  );

  tdm_phase_seq #(
    .SLOT_W(SLOT_W),
    .DUR_W (DUR_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .go       (!cfg_mode),
    .sup_rl   (sup_rl),
    .cli_rl   (cli_rl),
    .last_slot(last_slot),
    .run_q    (run_q),
    .phase_q  (phase_q),
    .slot_q   (slot_q),
    .start_q  (start_q),
    .nxt_run  (nxt_run),
    .nxt_phase(nxt_phase),
    .nxt_slot (nxt_slot)
  );

  // Grant is looked up from the next state so it lands in the same cycle as the phase.
  always_ff @(posedge clk) begin
    if (rst) grant_q <= '0;
    else if (nxt_run && (nxt_phase == PH_CLI) && own_vld)
      grant_q <= CLIENTS'(1) << own_id;
    else
      grant_q <= '0;
  end

  tdm_svc_counters #(
    .CLIENTS(CLIENTS),
    .CNT_W  (CNT_W)
  ) u_svc (
    .clk   (clk),
    .rst   (rst),
    .grant (grant_q),
    .counts(svc_count)
  );

  assign running     = run_q;
  assign sup_active  = run_q && (phase_q == PH_SUP);
  assign in_client   = run_q && (phase_q == PH_CLI);
  assign slot_idx    = slot_q;
  assign table_start = start_q;
  assign grant       = grant_q;

endmodule

// File: rtl/tdm_slot_sched_chk.sv
module tdm_slot_sched_chk #(
  parameter int SLOTS   = 16,
  parameter int CLIENTS = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     running,
  input logic                     sup_active,
  input logic                     in_client,
  input logic [$clog2(SLOTS)-1:0] slot_idx,
  input logic                     table_start,
  input logic [CLIENTS-1:0]       grant
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !running |-> (!sup_active && !in_client && grant == '0 && !table_start)); // R1

  AST_CLIENT_AFTER_SUP: assert property (@(posedge clk) disable iff (rst)
    (in_client && !$past(in_client)) |-> $past(sup_active)); // R2

  AST_SLOT_HELD_INTO_CLIENT: assert property (@(posedge clk) disable iff (rst)
    (in_client && $past(sup_active)) |-> (slot_idx == $past(slot_idx))); // R2

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R3

  AST_SUP_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    sup_active |-> (grant == '0)); // R3

  AST_START_AT_SLOT0: assert property (@(posedge clk) disable iff (rst)
    table_start |-> (sup_active && slot_idx == '0)); // R5

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(running) |-> running); // R7

endmodule

bind tdm_slot_sched tdm_slot_sched_chk #(
  .SLOTS  (SLOTS),
  .CLIENTS(CLIENTS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .running    (running),
  .sup_active (sup_active),
  .in_client  (in_client),
  .slot_idx   (slot_idx),
  .table_start(table_start),
  .grant      (grant)
);

// File: tb/tdm_slot_sched_test.sv
`timescale 1ns/1ps
module tdm_slot_sched_test;

  localparam int SLOTS = 16, CLIENTS = 4, DUR_W = 18, CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_mode = 1'b1, cfg_time_wr = 1'b0, cfg_own_wr = 1'b0, cfg_own_valid = 1'b0;
  logic [DUR_W-1:0] cfg_sup_len = '0, cfg_cli_len = '0;
  logic [4:0] cfg_slots = '0;
  logic [3:0] cfg_own_slot = '0;
  logic [1:0] cfg_own_client = '0;
  logic running, sup_active, in_client, table_start;
  logic [3:0] slot_idx;
  logic [CLIENTS-1:0] grant;
  logic [CLIENTS*CNT_W-1:0] svc_count;

  always #5 clk = ~clk;

  tdm_slot_sched #(.SLOTS(SLOTS), .CLIENTS(CLIENTS), .DUR_W(DUR_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_time_wr(cfg_time_wr),
    .cfg_sup_len(cfg_sup_len), .cfg_cli_len(cfg_cli_len), .cfg_slots(cfg_slots),
    .cfg_own_wr(cfg_own_wr), .cfg_own_slot(cfg_own_slot), .cfg_own_client(cfg_own_client),
    .cfg_own_valid(cfg_own_valid), .running(running), .sup_active(sup_active),
    .in_client(in_client), .slot_idx(slot_idx), .table_start(table_start),
    .grant(grant), .svc_count(svc_count));

  typedef struct packed {
    logic       sup;
    logic       cli;
    logic [3:0] slot;
    logic [3:0] gnt;
    logic       start;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_bad = 0;
  int m_sup, m_cli, m_n;
  bit m_vld[SLOTS];
  int m_own[SLOTS];
  int exp_svc[CLIENTS];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int svc(input int c);
    return int'(svc_count[c*CNT_W +: CNT_W]);
  endfunction

  // Monitor: compares one expected item per cycle, away from the clock edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(sup_active == e.sup, "R2 supervisor phase", int'(sup_active), int'(e.sup));
      chk(in_client == e.cli, "R2 client phase", int'(in_client), int'(e.cli));
      chk(slot_idx == e.slot, "R5 slot index", int'(slot_idx), int'(e.slot));
      chk(table_start == e.start, "R5 table start", int'(table_start), int'(e.start));
      chk(grant == e.gnt, (e.cli && e.gnt == 4'd0) ? "R4 unowned grant" : "R3 grant",
          int'(grant), int'(e.gnt));
    end
  end

  // Driver: pushes the expected sequence derived from the requirements.
  task automatic push_expect(input int cycles);
    int supE, cliE, nE, s, ph, rem;
    supE = (m_sup == 0) ? 1 : m_sup;
    cliE = (m_cli == 0) ? 1 : m_cli;
    nE   = (m_n == 0) ? 1 : ((m_n > SLOTS) ? SLOTS : m_n);
    s = 0; ph = 0; rem = supE - 1;
    for (int c = 0; c < CLIENTS; c++) exp_svc[c] = 0;
    for (int k = 0; k < cycles; k++) begin
      exp_t e;
      e.sup   = (ph == 0);
      e.cli   = (ph == 1);
      e.slot  = 4'(s);
      e.gnt   = (ph == 1 && m_vld[s]) ? 4'(1 << m_own[s]) : 4'd0;
      e.start = (ph == 0 && s == 0 && rem == supE - 1);
      if (ph == 1 && m_vld[s]) exp_svc[m_own[s]]++;
      exp_q.push_back(e);
      if (rem > 0) rem--;
      else if (ph == 0) begin ph = 1; rem = cliE - 1; end
      else begin ph = 0; rem = supE - 1; s = (s == nE - 1) ? 0 : s + 1; end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cfg_mode = 1'b1; cfg_time_wr = 1'b0; cfg_own_wr = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin m_vld[i] = 1'b0; m_own[i] = 0; end
    m_sup = 0; m_cli = 0; m_n = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_times(input int sup, input int cli, input int n);
    @(negedge clk);
    cfg_time_wr = 1'b1; cfg_sup_len = DUR_W'(sup); cfg_cli_len = DUR_W'(cli); cfg_slots = 5'(n);
    m_sup = sup; m_cli = cli; m_n = n;
    @(negedge clk);
    cfg_time_wr = 1'b0;
  endtask

  task automatic set_owner(input int s, input int c, input bit v);
    @(negedge clk);
    cfg_own_wr = 1'b1; cfg_own_slot = 4'(s); cfg_own_client = 2'(c); cfg_own_valid = v;
    m_vld[s] = v; m_own[s] = c;
    @(negedge clk);
    cfg_own_wr = 1'b0;
  endtask

  task automatic start_run(input int cycles);
    @(negedge clk);
    cfg_mode = 1'b0;
    @(posedge clk);
    push_expect(cycles);
  endtask

  task automatic drain_and_check_svc(input string tag);
    wait (exp_q.size() == 0);
    @(negedge clk);
    for (int c = 0; c < CLIENTS; c++) chk(svc(c) == exp_svc[c], tag, svc(c), exp_svc[c]);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset and idle configuration state
    do_reset();
    @(negedge clk);
    chk(running == 1'b0, "R1 running", int'(running), 0);
    chk(sup_active == 1'b0 && in_client == 1'b0, "R1 phase flags", int'({sup_active, in_client}), 0);
    chk(grant == '0, "R1 grant", int'(grant), 0);
    chk(table_start == 1'b0, "R1 table start", int'(table_start), 0);
    for (int c = 0; c < CLIENTS; c++) chk(svc(c) == 0, "R1 service counter", svc(c), 0);

    // Mixed table: two owned slots for client 1, one unowned slot (R2 R3 R4 R5 R8)
    set_times(3, 5, 4);
    set_owner(0, 1, 1'b1);
    set_owner(1, 3, 1'b0);
    set_owner(2, 2, 1'b1);
    set_owner(3, 1, 1'b1);
    @(negedge clk);
    chk(grant == '0 && running == 1'b0, "R1 idle while configuring", int'(grant), 0);
    start_run(64);
    drain_and_check_svc("R8 counters mixed table");
    chk(svc(1) == 20, "R8 client 1 two tables", svc(1), 20);

    // Zero lengths and zero slots behave as one (R6)
    do_reset();
    set_times(0, 0, 0);
    set_owner(0, 3, 1'b1);
    start_run(8);
    drain_and_check_svc("R6 counters zero settings");
    chk(svc(3) == 4, "R6 one-cycle client phases", svc(3), 4);

    // Oversized table length clips to capacity (R6)
    do_reset();
    set_times(1, 1, 20);
    set_owner(15, 0, 1'b1);
    start_run(36);
    drain_and_check_svc("R6 counters clipped table");

    // Writes after start are ignored (R7)
    do_reset();
    set_times(2, 2, 2);
    set_owner(0, 0, 1'b1);
    set_owner(1, 2, 1'b1);
    start_run(24);
    @(negedge clk);
    cfg_own_wr = 1'b1; cfg_own_slot = 4'd1; cfg_own_client = 2'd3; cfg_own_valid = 1'b1;
    cfg_time_wr = 1'b1; cfg_sup_len = 18'd7; cfg_cli_len = 18'd9; cfg_slots = 5'd5;
    cfg_mode = 1'b1;
    @(negedge clk);
    cfg_own_wr = 1'b0; cfg_time_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk(running == 1'b1, "R7 mode raise ignored", int'(running), 1);
    cfg_mode = 1'b0;
    drain_and_check_svc("R7 counters after ignored writes");
    chk(svc(3) == 0, "R7 owner write ignored", svc(3), 0);

    // Ten-slot table, five slots to client 0: 8 of every 17 cycles (R8)
    do_reset();
    set_times(1, 16, 10);
    for (int s = 0; s < 10; s += 2) set_owner(s, 0, 1'b1);
    start_run(170);
    drain_and_check_svc("R8 counters ten-slot table");
    chk(svc(0) * 17 == 170 * 8, "R8 service ratio 8/17", svc(0) * 17, 170 * 8);

    finish_run();
  end

endmodule